// File: doc/BRIEF.md
# Free-Running Timer with One Software-Compare Channel

This block is a memory-mapped timer. A counter counts up on the ticks of a programmable power-of-two clock divider. It wraps to zero after a programmable limit and raises an overflow flag when it does. A single compare channel raises its own flag, and an interrupt if that is enabled, when the counter steps onto a value that software has loaded.

Software normally leaves the limit at all ones, so the counter runs through its full range. To schedule an event it reads the count, adds a delay and writes the sum back as the compare value. The sum may wrap past the top of the counter. The software then waits for the interrupt and acknowledges it by writing one to a flag bit. Software can read the counter width from a read-only identification word, which lets one driver serve several widths.

Register access uses a simple 32-bit bus. Byte offsets select the registers and writes take effect at a clock edge. Reads are combinational.

Top module: `swcmp_timer`

## Requirements
- R1: After reset the counter reads 0, the limit (offset 0x18) reads all ones over CNT_W bits, the control word (offset 0x10) reads 0x3 (divide exponent 3, counter halted), and the channel control (0x20), status (0x1C) and `irq` all read 0.
- R2: The word at offset 0x04 reads CNT_W in bits 23:16 and zeros elsewhere. Writes to it change nothing.
- R3: Control bits 4:3 select the counter source. The value 1 advances the counter by one every 2^N clock cycles, where N is control bits 2:0. Any other value holds the counter still.
- R4: When the counter advances while it equals the limit, it goes to 0 and control bit 7 is set. Writing 1 to control bit 7 clears it.
- R5: Any write to offset 0x14 sets the counter to 0 and restarts the divider.
- R6: With channel control bits 5:2 equal to 1 (software compare), the channel flag sets on the edge at which the counter steps onto the compare value (offset 0x24). The flag reads as channel control bit 7 and as status bit 0. With any other mode value the flag never sets.
- R7: Writing 1 to status bit 0 or to channel control bit 7 clears the channel flag. Writing 0 to status bit 0 leaves it unchanged.
- R8: `irq` is high exactly while the channel flag and channel control bit 6 (interrupt enable) are both 1.
- R9: A compare value formed as count plus delay, taken modulo 2^CNT_W, is reached after the counter wraps through zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Compare interrupt, level |

## Verification
The embedded assertions check the counter and the channel on every cycle. The counter never moves without a divider tick or a clear. A wrap always lands on zero with the overflow flag set, and a clear always reaches zero. The channel flag only rises after a genuine compare hit and falls after a clear that is not cancelled by a simultaneous hit. Only the bench scenarios can show the things that depend on software-visible values: the divide ratios over random exponents and durations, reset values, the read-only identification word, interrupt gating, mode gating, and compare targets that wrap through zero.

// File: rtl/swcmp_timer_pkg.sv
// Package: shared register offsets and field encodings for the timer.
// Assumes byte offsets on an 8-bit address and a 32-bit data bus.
package swcmp_timer_pkg;
    localparam logic [7:0] OFS_IDENT  = 8'h04;
    localparam logic [7:0] OFS_CTRL   = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_LIMIT  = 8'h18;
    localparam logic [7:0] OFS_STAT   = 8'h1C;
    localparam logic [7:0] OFS_CHCTL  = 8'h20;
    localparam logic [7:0] OFS_CHVAL  = 8'h24;

    localparam int DIV_W = 3;

    typedef enum logic [1:0] {
        SRC_HALT = 2'd0,
        SRC_TICK = 2'd1
    } src_e;

    localparam logic [3:0]       CH_MODE_SWCMP = 4'h1;
    localparam logic [DIV_W-1:0] DIV_RESET     = 3'd3;
endpackage

// File: rtl/swcmp_prescale.sv
// Power-of-two divider: produces a one-cycle tick every 2^div cycles while run is high.
// Assumes div is held stable while running; clr restarts the phase at zero.
module swcmp_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PH_W = (1 << DIV_W) - 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] mask;

    // Low div bits of the phase that must all be ones for a tick.
    always_comb mask = ~({PH_W{1'b1}} << div);

    // Tick when the masked phase is complete.
    always_comb tick = run && ((phase & mask) == mask);

    // Phase advances while running and restarts on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase <= '0;
        else if (run)      phase <= phase + 1'b1;
    end
endmodule

// File: rtl/swcmp_counter.sv
// Up-counter with a programmable wrap limit and a sticky overflow flag.
// Assumes tick is already suppressed in the cycle of a clear.
module swcmp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         ovf_clr,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         ovf
);
    logic at_limit;

    // Next value taken on a tick: zero after the limit, else increment.
    always_comb begin
        at_limit = (cnt == limit);
        cnt_next = at_limit ? '0 : cnt + 1'b1;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= cnt_next;
    end

    // Overflow flag: a wrap wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf <= 1'b0;
        else if (tick && at_limit) ovf <= 1'b1;
        else if (ovf_clr)          ovf <= 1'b0;
    end

    // R3
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));
    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt == limit) |=> (cnt == '0 && ovf));
    // R5
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/swcmp_channel.sv
// Software-compare channel: sets a sticky flag when the counter steps onto the compare value.
// Assumes cnt_next is the value the counter takes on this tick.
module swcmp_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         armed,
    input  logic         clr,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] cmpv,
    output logic         flag
);
    logic hit;

    // A hit is a tick onto the compare value in software-compare mode.
    always_comb hit = tick && armed && (cnt_next == cmpv);

    // Flag register: a hit wins over a simultaneous clear so no event is lost.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R6
    flag_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(armed && tick && cnt_next == cmpv));
    // R7
    flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(armed && tick && cnt_next == cmpv)) |=> !flag);
endmodule

// File: rtl/swcmp_timer.sv
// Timer top: register file, read mux and wiring of divider, counter and compare channel.
// Assumes single-cycle writes (bus_sel && bus_wr) and combinational reads.
module swcmp_timer
    import swcmp_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam logic [31:0] IDENT_WORD = 32'(8'(CNT_W)) << 16;

    logic             wr_en;
    logic             wr_ctrl, wr_count, wr_limit, wr_stat, wr_chctl, wr_chval;
    logic [DIV_W-1:0] div_q;
    src_e             src_q;
    logic [CNT_W-1:0] limit_q, cmpv_q, cnt, cnt_next;
    logic [3:0]       chmode_q;
    logic             chie_q;
    logic             run, tick_raw, tick, ovf, flag, armed, flag_clr;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Write strobes per register.
    always_comb begin
        wr_en    = bus_sel && bus_wr;
        wr_ctrl  = wr_en && (bus_addr == OFS_CTRL);
        wr_count = wr_en && (bus_addr == OFS_COUNT);
        wr_limit = wr_en && (bus_addr == OFS_LIMIT);
        wr_stat  = wr_en && (bus_addr == OFS_STAT);
        wr_chctl = wr_en && (bus_addr == OFS_CHCTL);
        wr_chval = wr_en && (bus_addr == OFS_CHVAL);
    end

    // Control register fields: divide exponent and counter source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_RESET;
            src_q <= SRC_HALT;
        end else if (wr_ctrl) begin
            div_q <= bus_wdata[DIV_W-1:0];
            src_q <= src_e'(bus_wdata[4:3]);
        end
    end

    // Limit register, free-running after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        limit_q <= '1;
        else if (wr_limit) limit_q <= bus_wdata[CNT_W-1:0];
    end

    // Channel control and compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chmode_q <= '0;
            chie_q   <= 1'b0;
            cmpv_q   <= '0;
        end else begin
            if (wr_chctl) begin
                chmode_q <= bus_wdata[5:2];
                chie_q   <= bus_wdata[6];
            end
            if (wr_chval) cmpv_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Derived controls: run state, tick gating on clear, channel arming and flag clear.
    always_comb begin
        run      = (src_q == SRC_TICK);
        tick     = tick_raw && !wr_count;
        armed    = (chmode_q == CH_MODE_SWCMP);
        flag_clr = (wr_stat && bus_wdata[0]) || (wr_chctl && bus_wdata[7]);
    end

    swcmp_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(wr_count),
        .div(div_q), .tick(tick_raw)
    );

    swcmp_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(wr_count),
        .ovf_clr(wr_ctrl && bus_wdata[7]), .limit(limit_q),
        .cnt(cnt), .cnt_next(cnt_next), .ovf(ovf)
    );

    swcmp_channel #(.W(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick), .armed(armed), .clr(flag_clr),
        .cnt_next(cnt_next), .cmpv(cmpv_q), .flag(flag)
    );

    // Read mux.
    always_comb begin
        case (bus_addr)
            OFS_IDENT: bus_rdata = IDENT_WORD;
            OFS_CTRL:  bus_rdata = 32'({ovf, 2'b00, src_q, div_q});
            OFS_COUNT: bus_rdata = 32'(cnt);
            OFS_LIMIT: bus_rdata = 32'(limit_q);
            OFS_STAT:  bus_rdata = 32'(flag);
            OFS_CHCTL: bus_rdata = 32'({flag, chie_q, chmode_q, 2'b00});
            OFS_CHVAL: bus_rdata = 32'(cmpv_q);
            default:   bus_rdata = '0;
        endcase
    end

    // Level interrupt.
    always_comb irq = flag && chie_q;
endmodule

// File: tb/sim_swcmp_timer.sv
module sim_swcmp_timer;
    localparam int W = 8;
    localparam logic [7:0] A_ID = 8'h04, A_CTRL = 8'h10, A_CNT = 8'h14, A_LIM = 8'h18,
                           A_ST = 8'h1C, A_CHC = 8'h20, A_CHV = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    swcmp_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_count(int edges, int n, int lim);
        return 32'((edges >> n) % (lim + 1));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_from_zero(int n);
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h8 | 32'(n));
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int c, d;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_LIM, v);  check("R1 limit", v, 32'hFF);
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h3);
        rd(A_CHC, v);  check("R1 chctl", v, 0);
        rd(A_ST, v);   check("R1 status", v, 0);
        check("R1 irq", 32'(irq), 0);

        // R2 identification word, read-only
        rd(A_ID, v); check("R2 ident", v, 32'h0008_0000);
        wr(A_ID, 32'hFFFF_FFFF);
        rd(A_ID, v); check("R2 ident after write", v, 32'h0008_0000);

        // R3 halted counter holds
        edges(20);
        rd(A_CNT, v); check("R3 halted", v, 0);

        // R3 random divide exponents and durations
        for (int i = 0; i < 12; i++) begin
            int n, m;
            n = int'($urandom_range(0, 3));
            m = int'($urandom_range(1, 200));
            start_from_zero(n);
            edges(m);
            rd(A_CNT, v); check("R3 divided count", v, exp_count(m, n, 255));
        end
        start_from_zero(7);
        edges(300);
        rd(A_CNT, v); check("R3 divide 128", v, exp_count(300, 7, 255));
        wr(A_CTRL, 32'h18);
        rd(A_CNT, v); c = int'(v);
        edges(10);
        rd(A_CNT, v); check("R3 source value 3 halts", v, 32'(c));

        // R5 clear while running
        start_from_zero(0);
        edges(40);
        wr(A_CNT, 32'h55);
        rd(A_CNT, v); check("R5 clear", v, 0);
        edges(3);
        rd(A_CNT, v); check("R5 restart", v, 3);

        // R4 limit wrap and overflow flag
        wr(A_CTRL, 32'h0);
        wr(A_LIM, 32'h5);
        start_from_zero(0);
        edges(5);
        rd(A_CNT, v);  check("R4 at limit", v, 5);
        rd(A_CTRL, v); check("R4 no ovf yet", v, 32'h08);
        edges(1);
        rd(A_CNT, v);  check("R4 wrapped", v, 0);
        rd(A_CTRL, v); check("R4 ovf set", v, 32'h88);
        wr(A_CTRL, 32'h80);
        rd(A_CTRL, v); check("R4 ovf cleared", v, 0);
        wr(A_LIM, 32'hFF);

        // R6 and R8 compare with interrupt
        wr(A_CHV, 32'd12);
        wr(A_CHC, 32'h44);
        start_from_zero(0);
        edges(11);
        rd(A_ST, v); check("R6 before match", v, 0);
        check("R8 irq before", 32'(irq), 0);
        edges(1);
        rd(A_ST, v);  check("R6 status on match", v, 1);
        rd(A_CHC, v); check("R6 chctl flag", v, 32'hC4);
        check("R8 irq on match", 32'(irq), 1);
        edges(5);
        check("R8 irq holds", 32'(irq), 1);
        wr(A_CTRL, 32'h0);

        // R7 clearing
        wr(A_ST, 32'h0);
        rd(A_ST, v); check("R7 write 0 no effect", v, 1);
        wr(A_ST, 32'h1);
        rd(A_ST, v); check("R7 status clear", v, 0);
        check("R8 irq after clear", 32'(irq), 0);
        start_from_zero(0);
        edges(12);
        wr(A_CTRL, 32'h0);
        rd(A_ST, v); check("R7 retrigger", v, 1);
        wr(A_CHC, 32'hC4);
        rd(A_CHC, v); check("R7 chctl clear", v, 32'h44);

        // R8 interrupt gated by enable
        wr(A_CHC, 32'h04);
        start_from_zero(0);
        edges(12);
        wr(A_CTRL, 32'h0);
        rd(A_ST, v); check("R8 flag without enable", v, 1);
        check("R8 irq masked", 32'(irq), 0);
        wr(A_ST, 32'h1);

        // R6 mode not software compare: no flag
        wr(A_CHC, 32'h40);
        start_from_zero(0);
        edges(20);
        wr(A_CTRL, 32'h0);
        rd(A_ST, v); check("R6 disabled mode", v, 0);
        check("R6 disabled irq", 32'(irq), 0);

        // R9 compare target wrapping through zero
        wr(A_CHC, 32'h44);
        start_from_zero(0);
        edges(250);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); c = int'(v);
        d = 10;
        wr(A_CHV, 32'((c + d) % 256));
        wr(A_ST, 32'h1);
        wr(A_CTRL, 32'h8);
        edges(d - 1);
        rd(A_ST, v); check("R9 before wrapped match", v, 0);
        edges(1);
        rd(A_ST, v);  check("R9 wrapped match", v, 1);
        rd(A_CNT, v); check("R9 count at match", v, 32'((c + d) % 256));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule